// File: doc/BRIEF.md
# Paper Tape Reader Word Assembler

This block sits between the line interface of an 8-channel punched tape reader and an 18-bit reader buffer. A host command starts a read in one of two modes. The alphanumeric mode captures a single line with all eight channels. The binary mode collects three lines that carry the binary marker hole and packs their six data channels into one 18-bit word.

When the word is complete it is written into the reader buffer. Two command mode bits choose what happens next. If the bits are equal, the word waits in the buffer and a ready status bit goes high until software issues a read-buffer strobe. If the bits differ, the word is moved at once to the IO register output, together with a one-cycle load strobe.

The reader line interface is a valid/ready stream. The reader holds `line_data` and `line_valid` until `line_ready` is seen high at a rising edge. The block raises `line_ready` only while a read is in progress, so lines offered while the block is idle are held back and never consumed. The command, strobe and status pins are plain level or pulse signals.

Top module: `tape_word_asm`

## Requirements
- R1: After reset, `busy`, `buf_ready`, `io_load` and `line_ready` are 0 and `io_data` is 0.
- R2: A `cmd_start` pulse seen while idle makes `busy` and `line_ready` high from the next rising edge onward.
- R3: In alphanumeric mode (`cmd_binary`=0), the first line accepted ends the read. The word has `line_data[7:0]` in bits 7..0 and zeros in bits 17..8, where `line_data[k-1]` is tape channel k.
- R4: In binary mode (`cmd_binary`=1), each counted line supplies the 6-bit group `line_data[5:0]`, with channel 6 as the high bit of the group. The first counted line fills word bits 17..12, the second fills 11..6 and the third fills 5..0. For example, groups octal 42, 51 and 37 give octal 425137.
- R5: In binary mode, a line with `line_data[7]`=0 (channel 8 not punched) is consumed by the handshake but is not counted. `line_data[6]` (channel 7) never affects the word.
- R6: When `cmd_mode` bits are equal at start, a completed word goes to the buffer. `buf_ready` is 1 from the edge that accepts the last line, `io_data` is unchanged and `io_load` stays 0.
- R7: When `cmd_mode` bits differ at start, `io_data` takes the word and `io_load` is 1 for exactly one cycle, both from the edge that accepts the last line. `buf_ready` is not set.
- R8: A `cmd_rdbuf` pulse copies the buffer to `io_data`, pulses `io_load` for one cycle and clears `buf_ready`, all at the next edge.
- R9: A `rdr_return` pulse clears `buf_ready` at the next edge and leaves `io_data` unchanged.
- R10: A `cmd_start` arriving while `busy` is high is ignored. The running read keeps its mode and its count of lines.
- R11: `busy` and `line_ready` fall at the edge that accepts the last line. While idle, offered lines are not consumed and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start-read pulse |
| cmd_binary | input | 1 | 1 = binary three-line read, 0 = alphanumeric one-line read |
| cmd_mode | input | 2 | Transfer mode bits: differing bits = automatic transfer, equal bits = hold in buffer |
| cmd_rdbuf | input | 1 | Read-buffer strobe: copy buffer to IO register |
| rdr_return | input | 1 | Reader return pulse, clears ready status |
| line_valid | input | 1 | Reader offers a line |
| line_ready | output | 1 | Block accepts a line at this edge |
| line_data | input | 8 | Tape channels 8..1 in bits 7..0 |
| busy | output | 1 | Read in progress |
| buf_ready | output | 1 | Buffer holds a word not yet read |
| io_data | output | 18 | IO register value |
| io_load | output | 1 | One-cycle strobe when the IO register is loaded |

## Verification
Every result here comes from one register stage. The acceptance of the last line, a start pulse, a read-buffer strobe or a return pulse each shows on the outputs right after the next rising edge. The bench drives inputs on falling edges and samples on the falling edge that follows the edge under test. For the auto-transfer load strobe, it also samples one cycle later to confirm the strobe has dropped. Binary reads are fed with non-counting lines inserted at random, so the expected word is built from the counted groups only.

// File: rtl/tpr_pkg.sv
package tpr_pkg;
  parameter int LINE_W = 8;
  parameter int GRP_W  = 6;
  parameter int N_GRP  = 3;
  parameter int WORD_W = GRP_W * N_GRP;

  typedef enum logic {RD_ALPHA = 1'b0, RD_BIN = 1'b1} rd_mode_e;
endpackage

// File: rtl/tpr_assembler.sv
module tpr_assembler
  import tpr_pkg::*;
#(
  parameter int LW = LINE_W,
  parameter int GW = GRP_W,
  parameter int NG = N_GRP
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                bin_i,
  input  logic                auto_i,
  input  logic                line_valid_i,
  input  logic [LW-1:0]       line_data_i,
  output logic                line_ready_o,
  output logic                busy_o,
  output logic                auto_o,
  output logic                done_o,
  output logic [GW*NG-1:0]    word_o
);
  localparam int WW    = GW * NG;
  localparam int CNT_W = $clog2(NG + 1);

  logic              busy_q, auto_q;
  rd_mode_e          mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WW-1:0]     acc_q;
  logic              take, qual, last;
  logic [WW-1:0]     bin_word;

  assign take = line_valid_i && busy_q;
  assign qual = (mode_q == RD_ALPHA) || line_data_i[LW-1];
  assign last = (mode_q == RD_ALPHA) || (cnt_q == CNT_W'(NG - 1));

  generate
    if (NG > 1) begin : g_multi
      assign bin_word = {acc_q[WW-GW-1:0], line_data_i[GW-1:0]};
    end else begin : g_single
      assign bin_word = line_data_i[GW-1:0];
    end
  endgenerate

  assign word_o       = (mode_q == RD_ALPHA) ? WW'(line_data_i) : bin_word;
  assign done_o       = take && qual && last;
  assign line_ready_o = busy_q;
  assign busy_o       = busy_q;
  assign auto_o       = auto_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      auto_q <= 1'b0;
      mode_q <= RD_ALPHA;
      cnt_q  <= '0;
      acc_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        auto_q <= auto_i;
        mode_q <= bin_i ? RD_BIN : RD_ALPHA;
        cnt_q  <= '0;
        acc_q  <= '0;
      end
    end else if (take && qual) begin
      if (last) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        acc_q <= bin_word;
      end
    end
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && start_i |=> busy_q);
  // R10
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start_i && !take |=> $stable(mode_q) && $stable(auto_q) && $stable(cnt_q));
  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(NG - 1));
  // R5
  skip_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !qual |=> $stable(cnt_q) && busy_q);
endmodule

// File: rtl/tpr_out_stage.sv
module tpr_out_stage
  import tpr_pkg::*;
#(
  parameter int WW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_i,
  input  logic          auto_i,
  input  logic [WW-1:0] word_i,
  input  logic          rd_i,
  input  logic          ret_i,
  output logic [WW-1:0] io_o,
  output logic          load_o,
  output logic          ready_o
);
  logic [WW-1:0] buf_q, io_q;
  logic          load_q, rdy_q;
  logic          auto_xfer;

  assign auto_xfer = done_i && auto_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q  <= '0;
      io_q   <= '0;
      load_q <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      load_q <= 1'b0;
      if (done_i) buf_q <= word_i;
      if (auto_xfer) begin
        io_q   <= word_i;
        load_q <= 1'b1;
      end else if (rd_i) begin
        io_q   <= buf_q;
        load_q <= 1'b1;
      end
      if (done_i && !auto_i) rdy_q <= 1'b1;
      else if (rd_i || ret_i) rdy_q <= 1'b0;
    end
  end

  assign io_o    = io_q;
  assign load_o  = load_q;
  assign ready_o = rdy_q;

  // R6
  hold_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_i && !auto_i && !rd_i |=> rdy_q && !load_q && $stable(io_q));
  // R7
  auto_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_i && auto_i |=> load_q && io_q == $past(word_i));
  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i && !done_i |=> !rdy_q && load_q);
  // R9
  ret_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i && !rd_i && !done_i |=> !rdy_q && $stable(io_q));
endmodule

// File: rtl/tape_word_asm.sv
module tape_word_asm
  import tpr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_start,
  input  logic               cmd_binary,
  input  logic [1:0]         cmd_mode,
  input  logic               cmd_rdbuf,
  input  logic               rdr_return,
  input  logic               line_valid,
  output logic               line_ready,
  input  logic [LINE_W-1:0]  line_data,
  output logic               busy,
  output logic               buf_ready,
  output logic [WORD_W-1:0]  io_data,
  output logic               io_load
);
  logic              done, auto_run;
  logic [WORD_W-1:0] word;

  tpr_assembler #(.LW(LINE_W), .GW(GRP_W), .NG(N_GRP)) u_asm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (cmd_start),
    .bin_i        (cmd_binary),
    .auto_i       (cmd_mode[1] ^ cmd_mode[0]),
    .line_valid_i (line_valid),
    .line_data_i  (line_data),
    .line_ready_o (line_ready),
    .busy_o       (busy),
    .auto_o       (auto_run),
    .done_o       (done),
    .word_o       (word)
  );

  tpr_out_stage #(.WW(WORD_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .done_i  (done),
    .auto_i  (auto_run),
    .word_i  (word),
    .rd_i    (cmd_rdbuf),
    .ret_i   (rdr_return),
    .io_o    (io_data),
    .load_o  (io_load),
    .ready_o (buf_ready)
  );

  // R11
  idle_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !cmd_rdbuf |=> !io_load);
endmodule

// File: tb/tape_word_asm_test.sv
module tape_word_asm_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0, cmd_binary = 1'b0, cmd_rdbuf = 1'b0, rdr_return = 1'b0;
  logic [1:0]  cmd_mode = 2'b00;
  logic        line_valid = 1'b0;
  logic [7:0]  line_data = 8'h00;
  logic        line_ready, busy, buf_ready, io_load;
  logic [17:0] io_data;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  tape_word_asm uut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_binary(cmd_binary),
    .cmd_mode(cmd_mode), .cmd_rdbuf(cmd_rdbuf), .rdr_return(rdr_return),
    .line_valid(line_valid), .line_ready(line_ready), .line_data(line_data),
    .busy(busy), .buf_ready(buf_ready), .io_data(io_data), .io_load(io_load)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_rd(input logic bin, input logic [1:0] mode);
    cmd_binary = bin; cmd_mode = mode; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic send_line(input logic [7:0] d);
    while (!line_ready) @(negedge clk);
    line_data = d; line_valid = 1'b1;
    @(negedge clk);
    line_valid = 1'b0;
  endtask

  task automatic send_junk();
    send_line({1'b0, 7'($urandom)});
  endtask

  task automatic pulse_rd();
    cmd_rdbuf = 1'b1;
    @(negedge clk);
    cmd_rdbuf = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 buf_ready", buf_ready, 0);
    check("R1 io_load", io_load, 0);
    check("R1 line_ready", line_ready, 0);
    check("R1 io_data", io_data, 0);
  endtask

  task automatic t_idle_backpressure();
    line_data = 8'hFF; line_valid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R11 idle line_ready", line_ready, 0);
      check("R11 idle io_load", io_load, 0);
    end
    line_valid = 1'b0;
    check("R11 idle io_data", io_data, 0);
  endtask

  task automatic t_alpha_hold();
    start_rd(1'b0, 2'b00);
    check("R2 busy", busy, 1);
    check("R2 line_ready", line_ready, 1);
    send_line(8'hA5);
    check("R11 busy drop", busy, 0);
    check("R6 ready", buf_ready, 1);
    check("R6 no load", io_load, 0);
    check("R6 io kept", io_data, 0);
    pulse_rd();
    check("R8 io", io_data, 18'h000A5);
    check("R3 alpha word", io_data[17:8], 0);
    check("R8 load", io_load, 1);
    check("R8 ready clr", buf_ready, 0);
    @(negedge clk);
    check("R8 load pulse", io_load, 0);
  endtask

  task automatic t_alpha_auto();
    start_rd(1'b0, 2'b01);
    send_line(8'h3C);
    check("R7 io", io_data, 18'h0003C);
    check("R7 load", io_load, 1);
    check("R7 no ready", buf_ready, 0);
    @(negedge clk);
    check("R7 load pulse", io_load, 0);
  endtask

  task automatic t_bin_example();
    start_rd(1'b1, 2'b10);
    send_junk();
    send_line(8'h80 | 8'o42);
    send_junk();
    send_junk();
    check("R5 junk not counted", busy, 1);
    send_line(8'hC0 | 8'o51);
    send_line(8'h80 | 8'o37);
    check("R4 octal example", io_data, 18'o425137);
    check("R7 bin load", io_load, 1);
  endtask

  task automatic t_bin_random();
    for (int w = 0; w < 8; w++) begin
      logic [17:0] exp;
      exp = '0;
      start_rd(1'b1, (w % 2 == 0) ? 2'b01 : 2'b10);
      for (int g = 0; g < 3; g++) begin
        logic [5:0] grp;
        grp = 6'($urandom);
        while ($urandom % 2 == 1) send_junk();
        send_line({1'b1, 1'($urandom), grp});
        exp = {exp[11:0], grp};
      end
      check("R4 random word", io_data, exp);
      check("R5 random load", io_load, 1);
    end
  endtask

  task automatic t_ignore_start();
    logic [17:0] io_before;
    io_before = io_data;
    start_rd(1'b1, 2'b00);
    send_line(8'h80 | 8'o12);
    start_rd(1'b0, 2'b01);
    send_line(8'h7F);
    check("R10 still busy", busy, 1);
    check("R10 no load", io_load, 0);
    send_line(8'h80 | 8'o34);
    send_line(8'h80 | 8'o56);
    check("R10 hold kept", buf_ready, 1);
    check("R10 io unchanged", io_data, io_before);
    pulse_rd();
    check("R10 word", io_data, 18'o123456);
  endtask

  task automatic t_return();
    logic [17:0] io_before;
    start_rd(1'b0, 2'b11);
    send_line(8'h5A);
    io_before = io_data;
    check("R6 mode11 ready", buf_ready, 1);
    rdr_return = 1'b1;
    @(negedge clk);
    rdr_return = 1'b0;
    check("R9 ready clr", buf_ready, 0);
    check("R9 io unchanged", io_data, io_before);
    check("R9 no load", io_load, 0);
    pulse_rd();
    check("R8 read after return", io_data, 18'h0005A);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_backpressure();
    t_alpha_hold();
    t_alpha_auto();
    t_bin_example();
    t_bin_random();
    t_ignore_start();
    t_return();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule